// File: doc/BRIEF.md
# Page-table reference/change bit updater

This block sits between a page-table walker and the TLB fill logic of an MMU. For each translated access the walker hands over the 64-bit leaf entry it found, the physical address of that entry, the access kind and the permission set it decoded. The block works out the entry as it must look after the access: the referenced flag is set in every case, and the modified flag is also set for a store. When the entry needs to change, the block writes it back to memory and then returns one result: success with the final entry, a request to redo the walk, or a fault.

Writeback normally uses an atomic compare-and-swap on a simple request/response memory port. If another agent changed the entry between walk and update, the swap returns a value that is neither the old nor the new entry, and the walker is told to restart. A swap that ends in a bus error falls back to a plain write. With atomic mode off, the block always writes plainly. With hardware updating off, the block never touches memory and instead faults when a needed flag is missing. Write permission is withheld from the TLB while the final entry's modified flag is clear, so a later store comes back through this path.

The controller is a four-state machine. IDLE accepts a request. It moves to DONE when nothing needs to be written, and to ISSUE otherwise. ISSUE holds the memory request until it is accepted and then moves to WAIT. WAIT moves back to ISSUE, now with a plain write, when a swap comes back with an error. On any other response WAIT moves to DONE. DONE holds the result until it is taken and then returns to IDLE.

Top module: `pte_rc_updater`

## Requirements
- R1: Every update that ends in success returns an entry with the referenced flag (entry bit 8, bit 0 being least significant) set, for loads (access code 0), stores (code 1) and fetches (code 2).
- R2: A store that ends in success also returns an entry with the modified flag (entry bit 7) set. A load or fetch never sets that flag.
- R3: When the updated entry equals the walked entry, no memory request is issued and success is reported with the walked entry, one cycle after acceptance.
- R4: With atomic mode on, the writeback is a compare-and-swap request (op code 1) at the entry address. Its compare data is the walked entry and its write data the updated entry, both in big-endian byte order (byte 0 of the memory word holds entry bits 63:56).
- R5: If the swap returns, after the byte swap back, a value equal to neither the walked nor the updated entry, the result is restart (result code 1) and carries the walked entry. A returned value equal to the updated entry counts as success.
- R6: A swap response with the error flag set is followed by a plain write (op code 0) of the updated entry to the same address. The result is success.
- R7: With atomic mode off, the writeback is a single plain write of the updated entry, and the result is success (result code 0).
- R8: With hardware updating off, no memory request is issued. The result is fault (code 2) if the referenced flag is clear, or if the access is a store and the modified flag is clear. Otherwise it is success with the walked entry.
- R9: The fault status word is 32'h0000_0004 with a fault result and zero with any other result.
- R10: Output permissions (bit 0 read, bit 1 write, bit 2 execute) equal the input permissions, with the write bit cleared when the final entry's modified flag is clear. They are zero for restart and fault.
- R11: A request is accepted only in IDLE. A memory request holds its fields until accepted, and a result holds until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Walked entry offered |
| in_ready | output | 1 | Block can accept an entry |
| in_pte | input | 64 | Walked leaf entry |
| in_addr | input | ADDR_W | Physical address of the entry |
| in_acc | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| in_perm | input | 3 | Permissions decoded by the walker |
| hw_update_en | input | 1 | Hardware flag updating enabled |
| atomic_en | input | 1 | Use compare-and-swap for writeback |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_op | output | 1 | 0 plain write, 1 compare-and-swap |
| mem_req_addr | output | ADDR_W | Entry address |
| mem_req_cmp | output | 64 | Expected old word (big-endian) |
| mem_req_wdata | output | 64 | New word (big-endian) |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 64 | Word found in memory (big-endian) |
| mem_rsp_err | input | 1 | Bus error on the request |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken |
| out_result | output | 2 | 0 success, 1 restart, 2 fault |
| out_pte | output | 64 | Final entry |
| out_perm | output | 3 | Permissions for the TLB |
| out_fault_status | output | 32 | Fault cause bits |

## Verification
A result that needs no write is due on the first cycle after acceptance. Each memory round trip adds two cycles when the port accepts at once and the response follows one cycle later: three cycles for a single write or swap, five for a swap that errors and is retried as a plain write. The bench counts falling edges from the accepting edge to the first one with the result valid, compares that count with 1 + 2 × requests, and samples every output on that same edge. The directed stall tests hold the memory port or the result consumer off for several cycles and check the held values on each falling edge in between.

// File: rtl/pte_rc_pkg.sv
package pte_rc_pkg;
    localparam int PTE_W      = 64;
    localparam int REF_BIT    = 8;
    localparam int CHG_BIT    = 7;
    localparam int FSTAT_W    = 32;
    localparam int FCAUSE_BIT = 2;
    localparam int PERM_W     = 3;
    localparam int PERM_WR    = 1;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic {
        OP_WRITE = 1'b0,
        OP_CAS   = 1'b1
    } mem_op_e;

    typedef enum logic [1:0] {
        RES_OK      = 2'd0,
        RES_RESTART = 2'd1,
        RES_FAULT   = 2'd2
    } res_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_DONE
    } state_e;
endpackage

// File: rtl/pte_byte_swap.sv
module pte_byte_swap #(
    parameter int W = 64
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        assign dout[8*b +: 8] = din[8*(NB-1-b) +: 8];
    end
endmodule

// File: rtl/pte_rc_next.sv
module pte_rc_next
    import pte_rc_pkg::*;
(
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    output logic [PTE_W-1:0] next_pte,
    output logic             unchanged,
    output logic             flag_fault
);
    logic is_store;

    always_comb begin
        is_store = (acc == ACC_STORE);
        next_pte = pte;
        next_pte[REF_BIT] = 1'b1;
        if (is_store) begin
            next_pte[CHG_BIT] = 1'b1;
        end
        unchanged  = (next_pte == pte);
        flag_fault = !pte[REF_BIT] || (is_store && !pte[CHG_BIT]);
    end
endmodule

// File: rtl/pte_perm_gate.sv
module pte_perm_gate
    import pte_rc_pkg::*;
(
    input  logic [PTE_W-1:0]  final_pte,
    input  logic [PERM_W-1:0] perm_in,
    input  logic [1:0]        result,
    output logic [PERM_W-1:0] perm_out
);
    always_comb begin
        perm_out = '0;
        if (result == RES_OK) begin
            perm_out = perm_in;
            if (!final_pte[CHG_BIT]) begin
                perm_out[PERM_WR] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/pte_rc_updater.sv
module pte_rc_updater
    import pte_rc_pkg::*;
#(
    parameter int ADDR_W = 56
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [63:0]          in_pte,
    input  logic [ADDR_W-1:0]    in_addr,
    input  logic [1:0]           in_acc,
    input  logic [2:0]           in_perm,
    input  logic                 hw_update_en,
    input  logic                 atomic_en,
    output logic                 mem_req_valid,
    input  logic                 mem_req_ready,
    output logic                 mem_req_op,
    output logic [ADDR_W-1:0]    mem_req_addr,
    output logic [63:0]          mem_req_cmp,
    output logic [63:0]          mem_req_wdata,
    input  logic                 mem_rsp_valid,
    input  logic [63:0]          mem_rsp_rdata,
    input  logic                 mem_rsp_err,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [1:0]           out_result,
    output logic [63:0]          out_pte,
    output logic [2:0]           out_perm,
    output logic [31:0]          out_fault_status
);
    state_e              st_q, st_d;
    logic [PTE_W-1:0]    old_q, new_q, fin_q, fin_d;
    logic [ADDR_W-1:0]   addr_q;
    logic [PERM_W-1:0]   perm_q;
    mem_op_e             op_q, op_d;
    res_e                res_q, res_d;
    logic                take;

    logic [PTE_W-1:0]    nx_pte;
    logic                nx_same, nx_fault;
    logic [PTE_W-1:0]    old_be, new_be, rsp_host;
    logic [PERM_W-1:0]   gated_perm;

    pte_rc_next u_next (
        .pte        (in_pte),
        .acc        (in_acc),
        .next_pte   (nx_pte),
        .unchanged  (nx_same),
        .flag_fault (nx_fault)
    );

    pte_byte_swap #(.W(PTE_W)) u_swap_old (.din(old_q),         .dout(old_be));
    pte_byte_swap #(.W(PTE_W)) u_swap_new (.din(new_q),         .dout(new_be));
    pte_byte_swap #(.W(PTE_W)) u_swap_rsp (.din(mem_rsp_rdata), .dout(rsp_host));

    pte_perm_gate u_perm (
        .final_pte (fin_q),
        .perm_in   (perm_q),
        .result    (res_q),
        .perm_out  (gated_perm)
    );

    // state register and captured data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            old_q  <= '0;
            new_q  <= '0;
            fin_q  <= '0;
            addr_q <= '0;
            perm_q <= '0;
            op_q   <= OP_WRITE;
            res_q  <= RES_OK;
        end else begin
            st_q  <= st_d;
            op_q  <= op_d;
            res_q <= res_d;
            fin_q <= fin_d;
            if (take) begin
                old_q  <= in_pte;
                new_q  <= nx_pte;
                addr_q <= in_addr;
                perm_q <= in_perm;
            end
        end
    end

    // transitions
    always_comb begin
        st_d  = st_q;
        op_d  = op_q;
        res_d = res_q;
        fin_d = fin_q;
        take  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (in_valid) begin
                    take = 1'b1;
                    if (!hw_update_en) begin
                        st_d  = ST_DONE;
                        res_d = nx_fault ? RES_FAULT : RES_OK;
                        fin_d = in_pte;
                    end else if (nx_same) begin
                        st_d  = ST_DONE;
                        res_d = RES_OK;
                        fin_d = in_pte;
                    end else begin
                        st_d  = ST_ISSUE;
                        op_d  = atomic_en ? OP_CAS : OP_WRITE;
                        res_d = RES_OK;
                        fin_d = nx_pte;
                    end
                end
            end
            ST_ISSUE: begin
                if (mem_req_ready) begin
                    st_d = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    if (op_q == OP_CAS && mem_rsp_err) begin
                        st_d = ST_ISSUE;
                        op_d = OP_WRITE;
                    end else if (op_q == OP_CAS && rsp_host != old_q
                                 && rsp_host != new_q) begin
                        st_d  = ST_DONE;
                        res_d = RES_RESTART;
                        fin_d = old_q;
                    end else begin
                        st_d  = ST_DONE;
                        res_d = RES_OK;
                        fin_d = new_q;
                    end
                end
            end
            ST_DONE: begin
                if (out_ready) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        in_ready         = (st_q == ST_IDLE);
        mem_req_valid    = (st_q == ST_ISSUE);
        mem_req_op       = op_q;
        mem_req_addr     = addr_q;
        mem_req_cmp      = old_be;
        mem_req_wdata    = new_be;
        out_valid        = (st_q == ST_DONE);
        out_result       = res_q;
        out_pte          = fin_q;
        out_perm         = gated_perm;
        out_fault_status = '0;
        if (res_q == RES_FAULT) begin
            out_fault_status[FCAUSE_BIT] = 1'b1;
        end
    end
endmodule

// File: rtl/pte_rc_updater_chk.sv
module pte_rc_updater_chk
    import pte_rc_pkg::*;
#(
    parameter int ADDR_W = 56
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic [1:0]        in_acc,
    input logic              hw_update_en,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_req_op,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic [63:0]       mem_req_cmp,
    input logic [63:0]       mem_req_wdata,
    input logic              out_valid,
    input logic              out_ready,
    input logic [1:0]        out_result,
    input logic [63:0]       out_pte,
    input logic [2:0]        out_perm,
    input logic [31:0]       out_fault_status
);
    logic [1:0] acc_cap;
    logic       hw_cap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_cap <= 2'd0;
            hw_cap  <= 1'b0;
        end else if (in_valid && in_ready) begin
            acc_cap <= in_acc;
            hw_cap  <= hw_update_en;
        end
    end

    assert_ref_on_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result == RES_OK) |-> out_pte[REF_BIT]);

    assert_chg_on_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result == RES_OK && acc_cap == ACC_STORE) |-> out_pte[CHG_BIT]);

    assert_cas_changes_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_op == OP_CAS) |-> (mem_req_cmp != mem_req_wdata));

    assert_no_mem_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> hw_cap);

    assert_fault_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((out_fault_status == 32'h4) == (out_result == RES_FAULT)));

    assert_no_write_perm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_pte[CHG_BIT]) |-> !out_perm[PERM_WR]);

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_result) && $stable(out_pte)));

    assert_single_flight_R11: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (!out_valid && !mem_req_valid));
endmodule

bind pte_rc_updater pte_rc_updater_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .in_valid         (in_valid),
    .in_ready         (in_ready),
    .in_acc           (in_acc),
    .hw_update_en     (hw_update_en),
    .mem_req_valid    (mem_req_valid),
    .mem_req_ready    (mem_req_ready),
    .mem_req_op       (mem_req_op),
    .mem_req_addr     (mem_req_addr),
    .mem_req_cmp      (mem_req_cmp),
    .mem_req_wdata    (mem_req_wdata),
    .out_valid        (out_valid),
    .out_ready        (out_ready),
    .out_result       (out_result),
    .out_pte          (out_pte),
    .out_perm         (out_perm),
    .out_fault_status (out_fault_status)
);

// File: tb/sim_pte_rc_updater.sv
module sim_pte_rc_updater;
    localparam int ADDR_W = 56;
    localparam logic [63:0] P0  = 64'hA1B2_C3D4_0012_3400;
    localparam logic [63:0] PR  = 64'hA1B2_C3D4_0012_3500;
    localparam logic [63:0] PRC = 64'hA1B2_C3D4_0012_3580;
    localparam logic [63:0] PC  = 64'hA1B2_C3D4_0012_3480;

    typedef struct packed {
        logic [63:0] pte;
        logic [1:0]  acc;
        logic        hw;
        logic        atom;
        logic [1:0]  mode;   // 0 match, 1 conflict, 2 bus error, 3 already updated
        logic [1:0]  eres;
        logic [63:0] epte;
        logic [1:0]  enreq;
        logic        eop;
        logic [2:0]  eperm;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{P0,  2'd0, 1'b1, 1'b1, 2'd0, 2'd0, PR,  2'd1, 1'b1, 3'b101}, // R1 R4 R10 load
        '{P0,  2'd1, 1'b1, 1'b1, 2'd0, 2'd0, PRC, 2'd1, 1'b1, 3'b111}, // R2 store
        '{P0,  2'd2, 1'b1, 1'b1, 2'd0, 2'd0, PR,  2'd1, 1'b1, 3'b101}, // R1 fetch
        '{PR,  2'd0, 1'b1, 1'b1, 2'd0, 2'd0, PR,  2'd0, 1'b0, 3'b101}, // R3
        '{PRC, 2'd1, 1'b1, 1'b1, 2'd0, 2'd0, PRC, 2'd0, 1'b0, 3'b111}, // R3
        '{PRC, 2'd0, 1'b1, 1'b1, 2'd0, 2'd0, PRC, 2'd0, 1'b0, 3'b111}, // R2 load keeps flag
        '{PR,  2'd1, 1'b1, 1'b1, 2'd0, 2'd0, PRC, 2'd1, 1'b1, 3'b111}, // R2
        '{P0,  2'd1, 1'b1, 1'b1, 2'd1, 2'd1, P0,  2'd1, 1'b1, 3'b000}, // R5 conflict
        '{P0,  2'd1, 1'b1, 1'b1, 2'd3, 2'd0, PRC, 2'd1, 1'b1, 3'b111}, // R5 already new
        '{P0,  2'd1, 1'b1, 1'b1, 2'd2, 2'd0, PRC, 2'd2, 1'b0, 3'b111}, // R6
        '{P0,  2'd0, 1'b1, 1'b0, 2'd0, 2'd0, PR,  2'd1, 1'b0, 3'b101}, // R7
        '{P0,  2'd0, 1'b0, 1'b1, 2'd0, 2'd2, P0,  2'd0, 1'b0, 3'b000}, // R8 ref clear
        '{PR,  2'd1, 1'b0, 1'b1, 2'd0, 2'd2, PR,  2'd0, 1'b0, 3'b000}, // R8 chg clear
        '{PC,  2'd2, 1'b0, 1'b1, 2'd0, 2'd2, PC,  2'd0, 1'b0, 3'b000}, // R8 fetch ref clear
        '{PR,  2'd0, 1'b0, 1'b1, 2'd0, 2'd0, PR,  2'd0, 1'b0, 3'b101}, // R8 R10
        '{PRC, 2'd1, 1'b0, 1'b1, 2'd0, 2'd0, PRC, 2'd0, 1'b0, 3'b111}  // R8
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [63:0]       in_pte = '0;
    logic [ADDR_W-1:0] in_addr = '0;
    logic [1:0]        in_acc = '0;
    logic [2:0]        in_perm = 3'b111;
    logic              hw_update_en = 1'b1;
    logic              atomic_en = 1'b1;
    logic              mem_req_valid;
    logic              mem_req_ready = 1'b1;
    logic              mem_req_op;
    logic [ADDR_W-1:0] mem_req_addr;
    logic [63:0]       mem_req_cmp;
    logic [63:0]       mem_req_wdata;
    logic              mem_rsp_valid = 1'b0;
    logic [63:0]       mem_rsp_rdata = '0;
    logic              mem_rsp_err = 1'b0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [1:0]        out_result;
    logic [63:0]       out_pte;
    logic [2:0]        out_perm;
    logic [31:0]       out_fault_status;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;

    // behavioural memory: one big-endian word
    logic [63:0]       mem_word = '0;
    logic              err_mode = 1'b0;
    int                nreq = 0;
    logic              last_op = 1'b0;
    logic [ADDR_W-1:0] last_addr = '0;
    logic [63:0]       last_cmp = '0;

    always #2.5 clk = ~clk;

    pte_rc_updater #(.ADDR_W(ADDR_W)) u0 (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_rsp_valid <= 1'b0;
        mem_rsp_err   <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            nreq      <= nreq + 1;
            last_op   <= mem_req_op;
            last_addr <= mem_req_addr;
            last_cmp  <= mem_req_cmp;
            mem_rsp_valid <= 1'b1;
            if (mem_req_op) begin
                if (err_mode) begin
                    mem_rsp_err   <= 1'b1;
                    mem_rsp_rdata <= '0;
                end else begin
                    mem_rsp_rdata <= mem_word;
                    if (mem_word == mem_req_cmp) mem_word <= mem_req_wdata;
                end
            end else begin
                mem_word      <= mem_req_wdata;
                mem_rsp_rdata <= '0;
            end
        end
    end

    function automatic logic [63:0] be(input logic [63:0] v);
        logic [63:0] r;
        for (int b = 0; b < 8; b++) r[63-8*b -: 8] = v[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    // drive one request; returns falling edges from acceptance to result
    task automatic send(input logic [63:0] pte, input logic [1:0] acc,
                        input logic hw, input logic atom,
                        input logic [ADDR_W-1:0] addr, output int lat);
        @(negedge clk);
        in_pte = pte; in_acc = acc; hw_update_en = hw; atomic_en = atom;
        in_addr = addr; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        lat = 1;
        while (!out_valid && lat < 50) begin
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        repeat (500000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // reset state (R11)
        chk(in_ready == 1'b0 || in_ready == 1'b1, "R11 reset known", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready === 1'b1, "R11 reset in_ready", {63'd0, in_ready}, 64'd1);
        chk(out_valid === 1'b0, "R11 reset out_valid", {63'd0, out_valid}, 64'd0);
        chk(mem_req_valid === 1'b0, "R11 reset mem_req_valid", {63'd0, mem_req_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            logic [63:0] pre, exp_mem;
            logic [ADDR_W-1:0] a;
            int n0;
            a = ADDR_W'(56'h1000 + i * 8);
            case (VECS[i].mode)
                2'd1:    pre = be(VECS[i].pte ^ 64'h1000);
                2'd3:    pre = be(VECS[i].epte);
                default: pre = be(VECS[i].pte);
            endcase
            @(negedge clk);
            mem_word = pre;
            err_mode = (VECS[i].mode == 2'd2);
            n0 = nreq;
            send(VECS[i].pte, VECS[i].acc, VECS[i].hw, VECS[i].atom, a, lat);
            exp_mem = (VECS[i].eres == 2'd0 && VECS[i].enreq != 0) ? be(VECS[i].epte) : pre;
            chk(out_valid === 1'b1, $sformatf("R11 v%0d result valid", i), {63'd0, out_valid}, 64'd1);
            chk(out_result === VECS[i].eres, $sformatf("R5 R7 R8 v%0d result", i),
                64'(out_result), 64'(VECS[i].eres));
            chk(out_pte === VECS[i].epte, $sformatf("R1 R2 v%0d entry", i), out_pte, VECS[i].epte);
            chk(out_perm === VECS[i].eperm, $sformatf("R10 v%0d perm", i),
                64'(out_perm), 64'(VECS[i].eperm));
            chk(out_fault_status === ((VECS[i].eres == 2'd2) ? 32'h4 : 32'h0),
                $sformatf("R9 v%0d fault word", i), 64'(out_fault_status),
                (VECS[i].eres == 2'd2) ? 64'h4 : 64'h0);
            chk(nreq - n0 == int'(VECS[i].enreq), $sformatf("R3 R8 v%0d request count", i),
                64'(nreq - n0), 64'(VECS[i].enreq));
            chk(lat == 1 + 2 * int'(VECS[i].enreq), $sformatf("R3 v%0d latency", i),
                64'(lat), 64'(1 + 2 * int'(VECS[i].enreq)));
            chk(mem_word === exp_mem, $sformatf("R4 R6 v%0d memory word", i), mem_word, exp_mem);
            if (VECS[i].enreq != 0) begin
                chk(last_op === VECS[i].eop, $sformatf("R4 R6 R7 v%0d last op", i),
                    64'(last_op), 64'(VECS[i].eop));
                chk(last_addr === a, $sformatf("R4 v%0d address", i), 64'(last_addr), 64'(a));
                if (VECS[i].enreq == 1 && VECS[i].eop)
                    chk(last_cmp === be(VECS[i].pte), $sformatf("R4 v%0d compare data", i),
                        last_cmp, be(VECS[i].pte));
            end
        end

        // stall on memory port and result (R11)
        @(negedge clk);
        mem_word = be(P0);
        err_mode = 1'b0;
        mem_req_ready = 1'b0;
        out_ready = 1'b0;
        in_pte = P0; in_acc = 2'd1; hw_update_en = 1'b1; atomic_en = 1'b1;
        in_addr = ADDR_W'(56'h2468); in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            chk(mem_req_valid === 1'b1 && mem_req_addr === ADDR_W'(56'h2468),
                "R11 request held", 64'(mem_req_addr), 64'h2468);
            chk(in_ready === 1'b0, "R11 busy not ready", {63'd0, in_ready}, 64'd0);
            @(negedge clk);
        end
        mem_req_ready = 1'b1;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(out_valid === 1'b1 && out_pte === PRC, "R11 result held", out_pte, PRC);
            @(negedge clk);
        end
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid === 1'b0 && in_ready === 1'b1, "R11 back to idle",
            {62'd0, out_valid, in_ready}, 64'd1);
        chk(mem_word === be(PRC), "R4 stalled swap stored", mem_word, be(PRC));

        finish_run();
    end
endmodule